// File: doc/BRIEF.md
# Dual-Issue Compressed Fetch Buffer

This block sits between instruction memory and a pair of decoders. It takes in 64-bit fetch words and stores them as a ring of 16-bit parcels. From the oldest parcels it rebuilds whole instructions. Each instruction is either 32 bits long or a 16-bit compressed form. A 32-bit instruction may start in the last parcel of one fetch word and end in the first parcel of the next.

Each cycle the block offers up to two instructions, in program order, on two decode slots. Every slot carries the instruction bits, its own PC and a compressed flag. The fetch side and the decode side can each apply backpressure. A flush input empties the queue and moves the PC to a redirect address. Fetch then resumes with words that begin at that address.

Top module: `parcel_fetch_queue`

## Requirements
- R1: After reset, both decode slots are invalid and fetch_ready_o is high.
- R2: A slot's length comes from bits [1:0] of its first parcel. The value 2'b11 means a 32-bit instruction, presented as {second parcel, first parcel} with the compressed flag low. Any other value means a 16-bit instruction, presented zero-extended to 32 bits with the compressed flag high.
- R3: Parcels of an accepted fetch word are taken in order: bits [15:0] first, then [31:16], [47:32] and [63:48].
- R4: A 32-bit instruction whose lower parcel is the last parcel in the queue is not presented. Its lower parcel is held until the next fetch word supplies bits [15:0] as the upper half.
- R5: Slot 1 holds the instruction that follows slot 0, and slot 1 is never valid while slot 0 is invalid.
- R6: The slot 1 PC equals the slot 0 PC plus 2 for a compressed instruction and plus 4 otherwise. After every consumed instruction, the slot 0 PC advances by that instruction's length.
- R7: Slot 0 is consumed when it is valid and dec_ready_i[0] is high. Slot 1 is consumed only when it is valid, dec_ready_i[1] is high and slot 0 is consumed in the same cycle. An unconsumed slot 0 keeps its instruction and PC.
- R8: A fetch word is accepted only in a cycle where fetch_valid_i and fetch_ready_o are both high. fetch_ready_o is low whenever fewer than four free parcel slots remain.
- R9: Flush takes priority over everything else. In that cycle no fetch word is accepted and no slot is consumed. From the next cycle on, the queue is empty, any held half instruction is gone, fetch_ready_o is high, and the next instruction's PC is redirect_pc_i.
- R10: The queue holds 16 parcels. With decode stalled, exactly four fetch words are accepted, and fetch_ready_o is low once the fourth is in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush_i | input | 1 | Empty the queue and redirect |
| redirect_pc_i | input | 32 | PC of the first parcel after a flush |
| fetch_valid_i | input | 1 | Fetch word present |
| fetch_word_i | input | 64 | Fetch word, four parcels, lowest first |
| fetch_ready_o | output | 1 | Room for a whole fetch word |
| dec_valid_o | output | 2 | Per-slot instruction valid |
| dec_ready_i | input | 2 | Per-slot decoder ready |
| dec_instr_o | output | 2x32 | Per-slot instruction bits |
| dec_pc_o | output | 2x32 | Per-slot instruction PC |
| dec_compressed_o | output | 2 | Per-slot 16-bit flag |

## Verification
An accepted fetch word is written at the clock edge where both handshake signals are high. Its instructions show on the slots straight after that edge, because the slots decode the stored parcels combinationally. A consumed slot is removed at the edge where its ready is seen. A flush takes effect at the edge that follows its assertion. The bench therefore drives every input shortly after a rising edge and samples slots, ready and flush state at the falling edge. It pops its expected-instruction queue only for slots that fire at the coming edge, and it checks the flush and held-parcel results one full cycle after the causing stimulus.

// File: rtl/pfq_pkg.sv
package pfq_pkg;

    localparam int PARCEL_W = 16;
    localparam int INSN_W   = 32;

    typedef logic [PARCEL_W-1:0] parcel_t;

    // Decoded view of one decode slot
    typedef struct packed {
        logic              ok;    // enough parcels present and earlier slot ok
        logic              wide;  // 32-bit instruction
        logic [INSN_W-1:0] bits;  // instruction, zero-extended when 16-bit
    } slot_view_t;

    function automatic logic parcel_is_wide(parcel_t p);
        return p[1:0] == 2'b11;
    endfunction

    function automatic logic [INSN_W-1:0] assemble_insn(parcel_t lo, parcel_t hi);
        return parcel_is_wide(lo) ? {hi, lo} : {{(INSN_W-PARCEL_W){1'b0}}, lo};
    endfunction

endpackage

// File: rtl/pfq_parcel_ring.sv
module pfq_parcel_ring
    import pfq_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int PUSH_N = 4,
    parameter int WIN    = 4,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           flush_i,
    input  logic                           push_i,
    input  logic [PUSH_N*PARCEL_W-1:0]     push_data_i,
    input  logic [CW-1:0]                  pop_n_i,
    output logic [WIN-1:0][PARCEL_W-1:0]   win_o,
    output logic [CW-1:0]                  fill_o
);

    parcel_t       store [DEPTH];
    logic [AW-1:0] head_q;
    logic [AW-1:0] tail_q;
    logic [CW-1:0] fill_q;

    // parcel storage: no reset needed, fill_q qualifies contents
    always_ff @(posedge clk) begin
        if (push_i && !flush_i && !rst) begin
            for (int i = 0; i < PUSH_N; i++) begin
                store[tail_q + AW'(i)] <= push_data_i[i*PARCEL_W +: PARCEL_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush_i) begin
            head_q <= '0;
            tail_q <= '0;
            fill_q <= '0;
        end else begin
            if (push_i) begin
                tail_q <= tail_q + AW'(PUSH_N);
            end
            head_q <= head_q + AW'(pop_n_i);
            fill_q <= fill_q + (push_i ? CW'(PUSH_N) : CW'(0)) - pop_n_i;
        end
    end

    always_comb begin
        for (int i = 0; i < WIN; i++) begin
            win_o[i] = store[head_q + AW'(i)];
        end
    end

    assign fill_o = fill_q;

endmodule

// File: rtl/pfq_slot_decode.sv
module pfq_slot_decode
    import pfq_pkg::*;
#(
    parameter int WIN = 4,
    parameter int CW  = 5
) (
    input  logic [WIN-1:0][PARCEL_W-1:0] win_i,
    input  logic [CW-1:0]                fill_i,
    input  logic [CW-1:0]                offset_i,
    input  logic                         prev_ok_i,
    output slot_view_t                   view_o,
    output logic [CW-1:0]                next_offset_o
);

    parcel_t       lo;
    parcel_t       hi;
    logic          wide;
    logic [CW-1:0] need;

    always_comb begin
        lo = '0;
        hi = '0;
        for (int i = 0; i < WIN; i++) begin
            if (offset_i == CW'(i)) begin
                lo = win_i[i];
            end
            if (offset_i + CW'(1) == CW'(i)) begin
                hi = win_i[i];
            end
        end
    end

    assign wide          = parcel_is_wide(lo);
    assign need          = wide ? CW'(2) : CW'(1);
    assign next_offset_o = offset_i + need;

    assign view_o.ok   = prev_ok_i && (fill_i >= next_offset_o);
    assign view_o.wide = wide;
    assign view_o.bits = assemble_insn(lo, hi);

endmodule

// File: rtl/parcel_fetch_queue.sv
module parcel_fetch_queue
    import pfq_pkg::*;
#(
    parameter int              ADDR_W    = 32,
    parameter int              FETCH_W   = 64,
    parameter int              DEPTH     = 16,
    parameter int              NUM_SLOTS = 2,
    parameter logic [31:0]     RESET_PC  = 32'h8000_0000
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                flush_i,
    input  logic [ADDR_W-1:0]                   redirect_pc_i,
    input  logic                                fetch_valid_i,
    input  logic [FETCH_W-1:0]                  fetch_word_i,
    output logic                                fetch_ready_o,
    output logic [NUM_SLOTS-1:0]                dec_valid_o,
    input  logic [NUM_SLOTS-1:0]                dec_ready_i,
    output logic [NUM_SLOTS-1:0][INSN_W-1:0]    dec_instr_o,
    output logic [NUM_SLOTS-1:0][ADDR_W-1:0]    dec_pc_o,
    output logic [NUM_SLOTS-1:0]                dec_compressed_o
);

    localparam int PUSH_N = FETCH_W / PARCEL_W;
    localparam int WIN    = 2 * NUM_SLOTS;
    localparam int CW     = $clog2(DEPTH + 1);

    logic [WIN-1:0][PARCEL_W-1:0] win;
    logic [CW-1:0]                fill;
    logic [CW-1:0]                pop_n;
    logic                         push;
    logic [ADDR_W-1:0]            pc_q;

    slot_view_t                   view    [NUM_SLOTS];
    logic [CW-1:0]                offs    [NUM_SLOTS+1];
    logic                         prev_ok [NUM_SLOTS];
    logic [ADDR_W-1:0]            pcs     [NUM_SLOTS];
    logic [NUM_SLOTS-1:0]         fire;

    assign fetch_ready_o = (fill <= CW'(DEPTH - PUSH_N));
    assign push          = fetch_valid_i && fetch_ready_o && !flush_i;

    pfq_parcel_ring #(
        .DEPTH  (DEPTH),
        .PUSH_N (PUSH_N),
        .WIN    (WIN)
    ) u_ring (
        .clk         (clk),
        .rst         (rst),
        .flush_i     (flush_i),
        .push_i      (push),
        .push_data_i (fetch_word_i),
        .pop_n_i     (pop_n),
        .win_o       (win),
        .fill_o      (fill)
    );

    assign offs[0] = '0;
    assign pcs[0]  = pc_q;

    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
        if (k == 0) begin : g_first
            assign prev_ok[k] = 1'b1;
        end else begin : g_chain
            assign prev_ok[k] = view[k-1].ok;
        end

        pfq_slot_decode #(
            .WIN (WIN),
            .CW  (CW)
        ) u_dec (
            .win_i         (win),
            .fill_i        (fill),
            .offset_i      (offs[k]),
            .prev_ok_i     (prev_ok[k]),
            .view_o        (view[k]),
            .next_offset_o (offs[k+1])
        );

        if (k < NUM_SLOTS - 1) begin : g_next_pc
            assign pcs[k+1] = pcs[k] + (view[k].wide ? ADDR_W'(4) : ADDR_W'(2));
        end

        assign dec_valid_o[k]      = view[k].ok;
        assign dec_instr_o[k]      = view[k].bits;
        assign dec_compressed_o[k] = !view[k].wide;
        assign dec_pc_o[k]         = pcs[k];
    end

    // consumption is in order: a slot fires only behind a firing slot
    always_comb begin
        fire  = '0;
        pop_n = '0;
        for (int k = 0; k < NUM_SLOTS; k++) begin
            fire[k] = view[k].ok && dec_ready_i[k] && !flush_i
                      && ((k == 0) ? 1'b1 : fire[k-1]);
            if (fire[k]) begin
                pop_n = offs[k+1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= ADDR_W'(RESET_PC);
        end else if (flush_i) begin
            pc_q <= redirect_pc_i;
        end else begin
            pc_q <= pc_q + ADDR_W'({pop_n, 1'b0});
        end
    end

endmodule

// File: rtl/parcel_fetch_queue_chk.sv
module parcel_fetch_queue_chk #(
    parameter int ADDR_W    = 32,
    parameter int DEPTH     = 16,
    parameter int NUM_SLOTS = 2,
    parameter int CW        = 5
) (
    input logic                             clk,
    input logic                             rst,
    input logic                             flush_i,
    input logic                             fetch_ready_o,
    input logic [NUM_SLOTS-1:0]             dec_valid_o,
    input logic [NUM_SLOTS-1:0]             dec_ready_i,
    input logic [NUM_SLOTS-1:0][31:0]       dec_instr_o,
    input logic [NUM_SLOTS-1:0][ADDR_W-1:0] dec_pc_o,
    input logic [NUM_SLOTS-1:0]             dec_compressed_o,
    input logic [CW-1:0]                    fill
);

    // R10
    fill_bound_chk: assert property (@(posedge clk) disable iff (rst)
        fill <= CW'(DEPTH));

    // R9
    flush_empties_chk: assert property (@(posedge clk) disable iff (rst)
        flush_i |=> (dec_valid_o == '0) && fetch_ready_o);

    // R7
    slot0_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (dec_valid_o[0] && !dec_ready_i[0] && !flush_i)
        |=> dec_valid_o[0] && $stable(dec_instr_o[0]) && $stable(dec_pc_o[0]));

    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_k
        // R2
        len_flag_chk: assert property (@(posedge clk) disable iff (rst)
            dec_valid_o[k] |-> (dec_compressed_o[k] == (dec_instr_o[k][1:0] != 2'b11)));

        // R2
        upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
            (dec_valid_o[k] && dec_compressed_o[k]) |-> (dec_instr_o[k][31:16] == 16'h0));

        if (k > 0) begin : g_order
            // R5
            in_order_chk: assert property (@(posedge clk) disable iff (rst)
                dec_valid_o[k] |-> dec_valid_o[k-1]);

            // R6
            pc_step_chk: assert property (@(posedge clk) disable iff (rst)
                dec_valid_o[k] |-> dec_pc_o[k] ==
                    dec_pc_o[k-1] + (dec_compressed_o[k-1] ? ADDR_W'(2) : ADDR_W'(4)));
        end
    end

endmodule

bind parcel_fetch_queue parcel_fetch_queue_chk #(
    .ADDR_W    (ADDR_W),
    .DEPTH     (DEPTH),
    .NUM_SLOTS (NUM_SLOTS),
    .CW        (CW)
) u_chk (
    .clk              (clk),
    .rst              (rst),
    .flush_i          (flush_i),
    .fetch_ready_o    (fetch_ready_o),
    .dec_valid_o      (dec_valid_o),
    .dec_ready_i      (dec_ready_i),
    .dec_instr_o      (dec_instr_o),
    .dec_pc_o         (dec_pc_o),
    .dec_compressed_o (dec_compressed_o),
    .fill             (fill)
);

// File: tb/parcel_fetch_queue_test.sv
module parcel_fetch_queue_test;

    logic              clk = 1'b0;
    logic              rst;
    logic              flush;
    logic [31:0]       redirect;
    logic              fetch_valid;
    logic [63:0]       fetch_word;
    logic              fetch_ready;
    logic [1:0]        dec_valid;
    logic [1:0]        dec_ready;
    logic [1:0][31:0]  dec_instr;
    logic [1:0][31:0]  dec_pc;
    logic [1:0]        dec_comp;

    typedef struct {
        logic [31:0] instr;
        logic [31:0] pc;
        logic        comp;
    } exp_t;

    exp_t        exp_q[$];
    logic [15:0] pbuf[$];
    logic [63:0] words[$];
    logic [31:0] bpc;
    int          ready_mode;
    logic [15:0] lfsr;
    int          n_checks;
    int          n_fail;

    always #5 clk = ~clk;

    parcel_fetch_queue uut (
        .clk              (clk),
        .rst              (rst),
        .flush_i          (flush),
        .redirect_pc_i    (redirect),
        .fetch_valid_i    (fetch_valid),
        .fetch_word_i     (fetch_word),
        .fetch_ready_o    (fetch_ready),
        .dec_valid_o      (dec_valid),
        .dec_ready_i      (dec_ready),
        .dec_instr_o      (dec_instr),
        .dec_pc_o         (dec_pc),
        .dec_compressed_o (dec_comp)
    );

    task automatic check(input logic ok, input string req, input logic [63:0] act,
                         input logic [63:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", req, act, expv);
        end
    endtask

    // ---------------- scoreboard monitor ----------------
    task automatic compare_slot(input int k);
        exp_t e;
        if (exp_q.size() == 0) begin
            check(1'b0, "R3 unexpected instruction", {32'h0, dec_instr[k]}, 64'h0);
            return;
        end
        e = exp_q.pop_front();
        check(dec_instr[k] == e.instr, "R2 R3 R4 instr", {32'h0, dec_instr[k]}, {32'h0, e.instr});
        check(dec_pc[k] == e.pc, "R6 pc", {32'h0, dec_pc[k]}, {32'h0, e.pc});
        check(dec_comp[k] == e.comp, "R2 compressed flag", {63'h0, dec_comp[k]}, {63'h0, e.comp});
    endtask

    always @(negedge clk) begin
        logic [1:0] r;
        logic       f0;
        logic       f1;
        if (rst) begin
            dec_ready = 2'b00;
        end else begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            case (ready_mode)
                0:       r = 2'b11;
                1:       r = lfsr[1:0];
                default: r = 2'b00;
            endcase
            dec_ready = r;
            if (!flush) begin
                // R5: slot 1 never valid without slot 0
                check(!(dec_valid[1] && !dec_valid[0]), "R5 order",
                      {62'h0, dec_valid}, 64'h1);
                // R7: slot 1 only fires behind slot 0
                f0 = dec_valid[0] && r[0];
                f1 = f0 && dec_valid[1] && r[1];
                if (f0) compare_slot(0);
                if (f1) compare_slot(1);
            end
        end
    end

    // ---------------- program builder / driver ----------------
    task automatic add_c(input logic [15:0] v);
        logic [15:0] p;
        p = {v[15:2], (v[1:0] == 2'b11) ? 2'b10 : v[1:0]};
        pbuf.push_back(p);
        exp_q.push_back('{instr: {16'h0, p}, pc: bpc, comp: 1'b1});
        bpc += 32'd2;
    endtask

    task automatic add_w(input logic [31:0] v);
        logic [31:0] w;
        w = {v[31:2], 2'b11};
        pbuf.push_back(w[15:0]);
        pbuf.push_back(w[31:16]);
        exp_q.push_back('{instr: w, pc: bpc, comp: 1'b0});
        bpc += 32'd4;
    endtask

    task automatic pack();
        while ((pbuf.size() % 4) != 0) add_c(16'h0001);
        while (pbuf.size() != 0) begin
            logic [63:0] w;
            for (int i = 0; i < 4; i++) w[i*16 +: 16] = pbuf.pop_front();
            words.push_back(w);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic send_word(input logic [63:0] w);
        logic acc;
        fetch_valid = 1'b1;
        fetch_word  = w;
        forever begin
            #1 acc = fetch_ready;
            @(posedge clk);
            #2;
            if (acc) break;
        end
        fetch_valid = 1'b0;
    endtask

    task automatic send_next();
        send_word(words.pop_front());
    endtask

    task automatic send_all();
        while (words.size() != 0) send_next();
    endtask

    task automatic drain(input string req);
        int guard;
        guard = 0;
        while (exp_q.size() != 0 && guard < 3000) begin
            tick(1);
            guard++;
        end
        check(exp_q.size() == 0, req, 64'(exp_q.size()), 64'h0);
    endtask

    task automatic do_flush(input logic [31:0] pc);
        flush       = 1'b1;
        redirect    = pc;
        fetch_valid = 1'b1;              // must be ignored (R9)
        fetch_word  = 64'hFFFF_FFFF_FFFF_FFFF;
        exp_q.delete();
        pbuf.delete();
        words.delete();
        tick(1);
        flush       = 1'b0;
        fetch_valid = 1'b0;
        #1;
        check(dec_valid == 2'b00, "R9 slots empty after flush", {62'h0, dec_valid}, 64'h0);
        check(fetch_ready == 1'b1, "R9 ready after flush", {63'h0, fetch_ready}, 64'h1);
        bpc = pc;
        #1;
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    // ---------------- sequence ----------------
    initial begin
        n_checks    = 0;
        n_fail      = 0;
        ready_mode  = 0;
        lfsr        = 16'hACE1;
        rst         = 1'b1;
        flush       = 1'b0;
        redirect    = 32'h0;
        fetch_valid = 1'b0;
        fetch_word  = 64'h0;
        bpc         = 32'h8000_0000;
        tick(3);
        rst = 1'b0;
        tick(1);

        // R1: reset state
        #1;
        check(dec_valid == 2'b00, "R1 slots idle", {62'h0, dec_valid}, 64'h0);
        check(fetch_ready == 1'b1, "R1 fetch ready", {63'h0, fetch_ready}, 64'h1);
        #1;

        // R2 R3 R5: compressed only, full-rate decode
        for (int i = 0; i < 16; i++) add_c(16'h1230 + 16'(i * 4));
        pack();
        send_all();
        drain("R3 compressed stream drained");

        // R2: 32-bit only
        for (int i = 0; i < 8; i++) add_w(32'h00A0_0000 + 32'(i * 32'h1111));
        pack();
        send_all();
        drain("R2 wide stream drained");

        // R4 R6 R7: random mix with random decode backpressure
        ready_mode = 1;
        for (int i = 0; i < 60; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[0]) add_w({lfsr, lfsr ^ 16'h5A5A});
            else         add_c(lfsr ^ 16'h3C3C);
        end
        pack();
        send_all();
        drain("R7 mixed stream with backpressure drained");
        ready_mode = 0;

        // R4: straddling 32-bit held until the next word
        add_c(16'h0104);
        add_c(16'h0208);
        add_c(16'h030C);
        add_w(32'hBEEF_1237);
        pack();
        send_next();
        tick(6);
        #1;
        check(exp_q.size() == 4, "R4 only leading compressed consumed", 64'(exp_q.size()), 64'd4);
        check(dec_valid[0] == 1'b0, "R4 straddler withheld", {63'h0, dec_valid[0]}, 64'h0);
        #1;
        send_all();
        drain("R4 straddler completed");

        // R10 R8: capacity with decode stalled
        ready_mode = 2;
        tick(2);
        for (int i = 0; i < 12; i++) add_w(32'h0C00_0000 + 32'(i * 32'h0101));
        pack();
        send_next();
        send_next();
        send_next();
        #1;
        check(fetch_ready == 1'b1, "R8 ready with four slots free", {63'h0, fetch_ready}, 64'h1);
        #1;
        send_next();
        #1;
        check(fetch_ready == 1'b0, "R10 full after four words", {63'h0, fetch_ready}, 64'h0);
        #1;
        fetch_valid = 1'b1;
        fetch_word  = words[0];
        tick(3);
        #1;
        check(fetch_ready == 1'b0, "R8 word held off while full", {63'h0, fetch_ready}, 64'h0);
        check(dec_pc[0] == exp_q[0].pc, "R7 stalled slot keeps pc",
              {32'h0, dec_pc[0]}, {32'h0, exp_q[0].pc});
        #1;
        ready_mode = 0;
        send_all();
        drain("R10 full queue drained");

        // R9: flush drops a half-held parcel
        add_c(16'h0410);
        add_c(16'h0514);
        add_c(16'h0618);
        add_w(32'hDEAD_0003);
        pack();
        send_next();
        tick(6);
        do_flush(32'h8000_4000);
        add_c(16'h0720);
        add_w(32'h1357_9BDF);
        add_c(16'h0824);
        pack();
        send_all();
        drain("R9 stream after flush");

        // R9: flush of a full, stalled queue
        ready_mode = 2;
        tick(2);
        for (int i = 0; i < 8; i++) add_w(32'h0F00_0000 + 32'(i));
        pack();
        send_all();
        #1;
        check(fetch_ready == 1'b0, "R10 full before flush", {63'h0, fetch_ready}, 64'h0);
        #1;
        do_flush(32'h8001_0002);
        ready_mode = 0;
        add_w(32'h2468_ACE3);
        add_c(16'h0928);
        pack();
        send_all();
        drain("R9 stream after second flush");

        tick(2);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule